// File: doc/BRIEF.md
# Multi-Channel ADC Sample Sequencer

The sequencer walks a programmable list of up to eight analog channel numbers and, for each list slot, asks an external converter core for one conversion through a request/done handshake. Every result is written into a 32-entry FIFO together with the number of the channel it came from, so that software can drain the FIFO and sort samples without tracking the list position itself.

A run begins with a start strobe while the engine is enabled. It makes either one pass through the used slots or, in continuous mode, wraps back to the first slot and keeps going. Between two conversions the sequencer waits a programmable number of timebase ticks. The ticks come from the system clock through a parameterised prescaler. A stop strobe ends the run cleanly: a conversion already under way is finished and stored first. An occupancy threshold with an enable bit drives the interrupt output.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is idle. `busy`, `conv_req`, `irq` and `fifo_overflow` are 0, `fifo_empty` is 1 and `fifo_count` is 0.
- R2: A start strobe is accepted only in the idle state while `cfg_engine_en` is 1. A strobe given while `cfg_engine_en` is 0 issues no conversion request and leaves the FIFO empty.
- R3: `busy` is 1 in the cycle after an accepted start and stays 1 until the run returns to idle.
- R4: The slot at position i supplies channel `cfg_chan_list[3*i+2:3*i]`. Slots 0 to `cfg_last_idx` are used in ascending order, so a value of 0 in `cfg_last_idx` converts slot 0 only.
- R5: A FIFO entry holds the channel in bits 14:12 and the sample in bits 11:0. When `cfg_ten_bit` is 1, bits 11:10 of the entry are 0.
- R6: With `cfg_cont_en` at 0, the run goes idle once the result of the last used slot has been stored, and it issues no further requests.
- R7: With `cfg_cont_en` at 1, the slot after the last used slot is slot 0 and requests continue.
- R8: The cycle in which a `conv_done` is sampled is followed by (`cfg_delay`+1)×PRESCALE cycles without a request, and `conv_req` is high in the cycle after those.
- R9: A stop during a conversion waits for its `conv_done`, stores that result and then goes idle. A stop during the inter-sample wait goes idle at once, so `busy` is 0 in the next cycle and no further request is issued.
- R10: The FIFO holds 32 entries and is read oldest first. A pulse on `fifo_rd` removes the entry shown on `fifo_rdata`. `fifo_count` gives the occupancy modulo 32, so with 32 entries `fifo_full` is 1 and `fifo_count` is 0.
- R11: A result that arrives while the FIFO is full is discarded and sets `fifo_overflow`. The flag stays set until the next accepted start strobe.
- R12: While the FIFO is empty, `fifo_rdata` reads 0 and a read pulse changes neither `fifo_count` nor `fifo_empty`.
- R13: `irq` is 1 exactly when `cfg_irq_en` is 1 and the FIFO occupancy is at least `cfg_irq_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_engine_en | input | 1 | Engine enable; a start is ignored while this is 0 |
| cfg_cont_en | input | 1 | Continuous mode (wrap to slot 0) |
| cfg_ten_bit | input | 1 | Clear sample bits 11:10 in stored entries |
| cfg_chan_list | input | 24 | Eight 3-bit channel numbers, slot i at bits 3i+2:3i |
| cfg_last_idx | input | 3 | Index of the last used slot |
| cfg_delay | input | 8 | Inter-sample wait, in ticks minus one |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_irq_thresh | input | 5 | FIFO occupancy threshold for the interrupt |
| start_stb | input | 1 | Single-cycle start strobe |
| stop_stb | input | 1 | Single-cycle stop strobe |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Single-cycle conversion complete |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| fifo_rd | input | 1 | Read pulse, removes the head entry |
| fifo_rdata | output | 15 | Head entry: channel 14:12, sample 11:0 |
| fifo_count | output | 5 | Occupancy modulo 32 |
| fifo_full | output | 1 | FIFO holds 32 entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_overflow | output | 1 | Sticky flag for a discarded result |
| busy | output | 1 | A run is in progress |
| irq | output | 1 | Occupancy threshold interrupt |

## Verification
The hardest state to reach is a result arriving while all 32 entries are occupied. The bench gets there by running continuous mode with a one-tick wait and without draining, until the overflow flag rises. It then stops the run and reads all 32 entries back. This shows that the oldest samples were kept and the newest ones were dropped. Stopping inside the inter-sample wait also needs exact timing: the bench uses a long wait and places the stop strobe a few cycles after the converter's done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W     = 3;
  localparam int SLOTS    = 8;
  localparam int SAMPLE_W = 12;
  localparam int NARROW_W = 10;
  localparam int ENTRY_W  = CH_W + SAMPLE_W;
  localparam int LIST_W   = CH_W * SLOTS;
  localparam int IDX_W    = $clog2(SLOTS);
  localparam int DLY_W    = 8;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_GAP} seq_state_t;

  // channel number held in list slot idx
  function automatic logic [CH_W-1:0] slot_chan(input logic [LIST_W-1:0] list,
                                                input logic [IDX_W-1:0] idx);
    return list[idx*CH_W +: CH_W];
  endfunction

  // FIFO entry: channel above sample, optional narrowing of the sample
  function automatic logic [ENTRY_W-1:0] make_entry(input logic [CH_W-1:0] chan,
                                                    input logic [SAMPLE_W-1:0] data,
                                                    input logic narrow);
    logic [SAMPLE_W-1:0] keep;
    keep = '1;
    if (narrow) begin
      keep = '0;
      keep[NARROW_W-1:0] = '1;
    end
    return {chan, data & keep};
  endfunction
endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart)            cnt <= '0;
    else if (run)                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && !restart && (cnt == LAST);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LIST_W-1:0]   chan_list,
  input  logic [IDX_W-1:0]    last_idx,
  input  logic                engine_en,
  input  logic                cont_en,
  input  logic [DLY_W-1:0]    delay,
  input  logic                start_stb,
  input  logic                stop_stb,
  input  logic                tick,
  input  logic                conv_done,
  output logic                conv_req,
  output logic [CH_W-1:0]     conv_chan,
  output logic                push,
  output logic                start_ok,
  output logic                in_gap,
  output logic                busy
);
  seq_state_t       state;
  logic [IDX_W-1:0] slot;
  logic [DLY_W-1:0] tick_cnt;
  logic             stop_pend;
  logic             last_slot;

  assign start_ok  = (state == S_IDLE) && start_stb && engine_en;
  assign conv_req  = (state == S_CONV);
  assign in_gap    = (state == S_GAP);
  assign busy      = (state != S_IDLE);
  assign conv_chan = slot_chan(chan_list, slot);
  assign push      = conv_req && conv_done;
  assign last_slot = (slot == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      slot      <= '0;
      tick_cnt  <= '0;
      stop_pend <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start_ok) begin
          state     <= S_CONV;
          slot      <= '0;
          stop_pend <= 1'b0;
        end
        S_CONV: begin
          if (stop_stb) stop_pend <= 1'b1;
          if (conv_done) begin
            if (stop_pend || stop_stb || (last_slot && !cont_en)) begin
              state <= S_IDLE;
            end else begin
              state    <= S_GAP;
              slot     <= last_slot ? '0 : slot + 1'b1;
              tick_cnt <= '0;
            end
          end
        end
        S_GAP: begin
          if (stop_stb)                     state <= S_IDLE;
          else if (tick && tick_cnt == delay) state <= S_CONV;
          else if (tick)                    tick_cnt <= tick_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy) else $error("busy not raised after start");
  p_req_drop_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !conv_req) else $error("request held after done");
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> conv_req) else $error("request withdrawn early");
  p_stop_in_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && stop_stb) |=> !busy) else $error("stop in gap not honoured");
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  input  logic             clr_ovf,
  output logic [W-1:0]     rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      level <= level + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      if (clr_ovf)            overflow <= 1'b0;
      else if (push && full)  overflow <= 1'b1;
    end
  end

  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full) else $error("full lost without a read");
  p_drop_sets_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> overflow) else $error("drop not flagged");
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow) else $error("overflow flag cleared");
  p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty) else $error("read of empty FIFO moved it");
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_engine_en,
  input  logic                 cfg_cont_en,
  input  logic                 cfg_ten_bit,
  input  logic [LIST_W-1:0]    cfg_chan_list,
  input  logic [IDX_W-1:0]     cfg_last_idx,
  input  logic [DLY_W-1:0]     cfg_delay,
  input  logic                 cfg_irq_en,
  input  logic [$clog2(FIFO_DEPTH)-1:0] cfg_irq_thresh,
  input  logic                 start_stb,
  input  logic                 stop_stb,
  output logic                 conv_req,
  output logic [CH_W-1:0]      conv_chan,
  input  logic                 conv_done,
  input  logic [SAMPLE_W-1:0]  conv_data,
  input  logic                 fifo_rd,
  output logic [ENTRY_W-1:0]   fifo_rdata,
  output logic [$clog2(FIFO_DEPTH)-1:0] fifo_count,
  output logic                 fifo_full,
  output logic                 fifo_empty,
  output logic                 fifo_overflow,
  output logic                 busy,
  output logic                 irq
);
  localparam int CW = $clog2(FIFO_DEPTH);

  logic          tick, push, start_ok, in_gap;
  logic [CW:0]   level;

  adc_seq_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(!in_gap), .run(in_gap), .tick(tick));

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_list(cfg_chan_list), .last_idx(cfg_last_idx),
    .engine_en(cfg_engine_en), .cont_en(cfg_cont_en), .delay(cfg_delay),
    .start_stb(start_stb), .stop_stb(stop_stb), .tick(tick), .conv_done(conv_done),
    .conv_req(conv_req), .conv_chan(conv_chan), .push(push), .start_ok(start_ok),
    .in_gap(in_gap), .busy(busy));

  adc_seq_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push),
    .wdata(make_entry(conv_chan, conv_data, cfg_ten_bit)),
    .pop(fifo_rd), .clr_ovf(start_ok), .rdata(fifo_rdata), .level(level),
    .full(fifo_full), .empty(fifo_empty), .overflow(fifo_overflow));

  assign fifo_count = level[CW-1:0];
  assign irq        = cfg_irq_en && (level >= {1'b0, cfg_irq_thresh});

  p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_req) else $error("request while idle");
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int P = 4;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_engine_en = 0, cfg_cont_en = 0, cfg_ten_bit = 0, cfg_irq_en = 0;
  logic [23:0] cfg_chan_list = '0;
  logic [2:0]  cfg_last_idx = '0;
  logic [7:0]  cfg_delay = '0;
  logic [4:0]  cfg_irq_thresh = '0;
  logic start_stb = 0, stop_stb = 0, conv_done = 0, fifo_rd = 0;
  logic [11:0] conv_data = '0;
  logic conv_req, fifo_full, fifo_empty, fifo_overflow, busy, irq;
  logic [2:0]  conv_chan;
  logic [14:0] fifo_rdata;
  logic [4:0]  fifo_count;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nlog = 0, done_cyc = -1, gap_last = 0;
  logic [11:0] log_data [256];
  logic [2:0]  log_chan [256];
  logic [2:0]  chans [8];

  adc_seq_top #(.PRESCALE(P)) dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] mk(int n);
    return 12'hC00 | 12'((n * 13) & 'h3FF);
  endfunction
  function automatic logic [14:0] exp_entry(logic [2:0] c, logic [11:0] d, logic nb);
    return {c, nb ? {2'b00, d[9:0]} : d};
  endfunction

  // behavioural converter
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        log_chan[nlog] = conv_chan;
        if (done_cyc >= 0) gap_last = cyc - done_cyc;
        repeat (LAT - 1) @(negedge clk);
        conv_data = mk(nlog);
        log_data[nlog] = conv_data;
        conv_done = 1;
        done_cyc = cyc;
        nlog = nlog + 1;
        @(negedge clk);
        conv_done = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_list(input logic [2:0] c0, c1, c2, c3);
    chans[0] = c0; chans[1] = c1; chans[2] = c2; chans[3] = c3;
    for (int i = 4; i < 8; i++) chans[i] = 3'(i);
    for (int i = 0; i < 8; i++) cfg_chan_list[i*3 +: 3] = chans[i];
  endtask

  task automatic pulse_start();
    @(negedge clk) start_stb = 1;
    @(negedge clk) start_stb = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_stb = 1;
    @(negedge clk) stop_stb = 0;
  endtask

  task automatic pop(output logic [14:0] v);
    @(negedge clk);
    v = fifo_rdata;
    fifo_rd = 1;
    @(negedge clk) fifo_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic drain();
    logic [14:0] v;
    for (int i = 0; i < 40 && !fifo_empty; i++) pop(v);
  endtask

  task automatic new_run();
    @(negedge clk);
    nlog = 0;
    done_cyc = -1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !conv_req && !irq && !fifo_overflow, "R1 idle flags", {busy, conv_req, irq, fifo_overflow}, 0);
    chk(fifo_empty && fifo_count == 0, "R1 fifo empty", fifo_count, 0);
  endtask

  task automatic t_disabled();
    new_run();
    cfg_engine_en = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(nlog == 0 && !busy, "R2 start ignored when disabled", nlog, 0);
    chk(fifo_empty, "R2 fifo stays empty", fifo_count, 0);
  endtask

  task automatic t_single();
    logic [14:0] v;
    new_run();
    cfg_engine_en = 1; cfg_cont_en = 0; cfg_delay = 1;
    set_list(3'd5, 3'd2, 3'd7, 3'd1);
    cfg_last_idx = 2;
    pulse_start();
    chk(busy, "R3 busy after start", busy, 1);
    wait_idle();
    repeat (30) @(negedge clk);
    chk(nlog == 3 && fifo_count == 3, "R6 one pass only", fifo_count, 3);
    cfg_irq_en = 1; cfg_irq_thresh = 3;
    @(negedge clk) chk(irq, "R13 irq at threshold", irq, 1);
    cfg_irq_thresh = 4;
    @(negedge clk) chk(!irq, "R13 irq below threshold", irq, 0);
    cfg_irq_en = 0; cfg_irq_thresh = 1;
    @(negedge clk) chk(!irq, "R13 irq disabled", irq, 0);
    for (int i = 0; i < 3; i++) begin
      pop(v);
      chk(v == exp_entry(chans[i], log_data[i], 0), "R4 R5 entry order and format", v, exp_entry(chans[i], log_data[i], 0));
    end
    chk(fifo_empty, "R10 empty after reads", fifo_count, 0);
  endtask

  task automatic t_one_slot_narrow();
    logic [14:0] v;
    new_run();
    cfg_ten_bit = 1; cfg_last_idx = 0;
    set_list(3'd6, 3'd1, 3'd1, 3'd1);
    pulse_start();
    wait_idle();
    repeat (30) @(negedge clk);
    chk(nlog == 1 && fifo_count == 1, "R4 last index zero gives one slot", nlog, 1);
    pop(v);
    chk(v == {3'd6, 2'b00, log_data[0][9:0]}, "R5 ten-bit entry", v, {3'd6, 2'b00, log_data[0][9:0]});
    cfg_ten_bit = 0;
  endtask

  task automatic t_gap();
    logic [14:0] v;
    new_run();
    cfg_last_idx = 1; cfg_delay = 10;
    pulse_start();
    wait_idle();
    chk(gap_last == 11 * P + 1, "R8 gap delay 10", gap_last, 11 * P + 1);
    drain();
    new_run();
    cfg_delay = 0;
    pulse_start();
    wait_idle();
    chk(gap_last == P + 1, "R8 gap delay 0", gap_last, P + 1);
    drain();
  endtask

  task automatic t_cont_stop_conv();
    logic [14:0] v;
    new_run();
    cfg_cont_en = 1; cfg_delay = 2; cfg_last_idx = 1;
    set_list(3'd3, 3'd6, 3'd0, 3'd0);
    pulse_start();
    wait (nlog == 4);
    @(posedge conv_req);
    @(negedge clk) stop_stb = 1;
    @(negedge clk) stop_stb = 0;
    chk(busy, "R9 conversion finishes after stop", busy, 1);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(nlog == 5 && fifo_count == 5, "R9 last result stored", fifo_count, 5);
    for (int i = 0; i < 5; i++) begin
      pop(v);
      chk(v == exp_entry(chans[i % 2], log_data[i], 0), "R7 wrap to slot 0", v, exp_entry(chans[i % 2], log_data[i], 0));
    end
  endtask

  task automatic t_stop_gap();
    new_run();
    cfg_delay = 50;
    pulse_start();
    wait (nlog == 2);
    repeat (3) @(negedge clk);
    pulse_stop();
    chk(!busy, "R9 stop in gap idles", busy, 0);
    repeat (300) @(negedge clk);
    chk(nlog == 2 && fifo_count == 2, "R9 no request after stop", nlog, 2);
    drain();
  endtask

  task automatic t_overflow();
    logic [14:0] v;
    new_run();
    cfg_delay = 0; cfg_last_idx = 3;
    set_list(3'd1, 3'd4, 3'd2, 3'd7);
    pulse_start();
    for (int i = 0; i < 3000 && !fifo_overflow; i++) @(negedge clk);
    pulse_stop();
    wait_idle();
    chk(fifo_full && fifo_count == 0 && !fifo_empty, "R10 full with count 0", fifo_count, 0);
    chk(fifo_overflow && nlog > 32, "R11 drop flagged", nlog, 33);
    for (int i = 0; i < 32; i++) begin
      pop(v);
      chk(v == exp_entry(chans[i % 4], log_data[i], 0), "R11 oldest kept", v, exp_entry(chans[i % 4], log_data[i], 0));
    end
    chk(fifo_empty && fifo_count == 0, "R10 empty after 32 reads", fifo_count, 0);
    pop(v);
    chk(v == 0, "R12 empty read data zero", v, 0);
    chk(fifo_empty && fifo_count == 0, "R12 empty read no effect", fifo_count, 0);
    chk(fifo_overflow, "R11 flag sticky", fifo_overflow, 1);
    new_run();
    cfg_cont_en = 0; cfg_last_idx = 0;
    pulse_start();
    chk(!fifo_overflow, "R11 start clears flag", fifo_overflow, 0);
    wait_idle();
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_single();
    t_one_slot_narrow();
    t_gap();
    t_cont_stop_conv();
    t_stop_gap();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule